// File: doc/BRIEF.md
# Dual-Mode Delay Setting Register

This block holds the 8-bit code that selects the tap of a programmable delay element. Code zero selects the shortest delay, which is the element's built-in delay, and each increment adds one equal step, giving 256 settings. The code can be loaded in two ways, chosen by a mode pin. In parallel mode an 8-bit bus is passed through to the active code while the enable input is high, and the code is held when enable is low. In serial mode a three-wire port (enable, serial clock, serial data) shifts a new value into a shadow register. The active code only takes that value when enable falls.

While bits are shifted in, the old shadow contents leave on a serial output, most significant bit first. Stages can therefore be chained output to input. Wiring the last stage's output back to the first stage's input gives a readback that puts the original contents back. The serial output shares its pin with bit 0 of the parallel bus, so an output-enable is provided and is asserted only in serial mode.

Enable, serial clock, serial data, mode and bus are sampled into the system clock domain by a synchronizer. Edges are found from the sampled values, so all state changes on the system clock.

Top module: `delay_code_reg`

## Requirements
- R1: A synchronous reset sets the active code and the shadow register to zero, so the serial output reads 0.
- R2: `mode_par`=1 selects parallel mode and `mode_par`=0 selects serial mode. `sq_oe` is 1 only in serial mode.
- R3: In parallel mode with `en_in`=1, `code_out` follows `pbus_in` a few system clocks after the bus changes.
- R4: In parallel mode with `en_in`=0, changes on `pbus_in` leave `code_out` unchanged.
- R5: In serial mode with `en_in`=1, each rising edge of `sclk_in` shifts `sdata_in` into bit 0 of the shadow register while the other bits move up one place. A byte is therefore sent bit 7 first.
- R6: In serial mode `code_out` keeps its value while `en_in`=1. On the falling edge of `en_in`, it takes the shadow register value.
- R7: Rising edges of `sclk_in` while `en_in`=0 do not change the shadow register, and they do not change the active code.
- R8: `sq_out` always shows bit 7 of the shadow register. With the output looped back to the input, eight clocks per stage restore the shadow contents, so the active code is unchanged when enable falls.
- R9: In a chain of stages, 8 clocks per stage load every stage. The first byte sent ends in the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_par | input | 1 | 1 = parallel load, 0 = serial load |
| en_in | input | 1 | Enable / transfer strobe |
| sclk_in | input | 1 | Serial shift clock |
| sdata_in | input | 1 | Serial data in |
| pbus_in | input | 8 | Parallel code bus |
| code_out | output | 8 | Active delay code |
| sq_out | output | 1 | Serial data out (shadow bit 7) |
| sq_oe | output | 1 | Drive enable for the shared serial-out / bus-bit-0 pin |

## Verification
The hardest situation to reach is a looped readback through a two-stage chain. It must return each stage's bits in the right order and leave both active codes unchanged when enable falls. The stimulus first writes distinct bytes into two chained instances. It then closes the loop from the last stage's output to the first stage's input. It compares all sixteen bits seen on the output before each serial clock edge against the bytes it wrote, and then drops enable and checks both codes.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam logic MODE_SERIAL   = 1'b0;
    localparam logic MODE_PARALLEL = 1'b1;

    // sampled control inputs
    typedef struct packed {
        logic mode;
        logic en;
        logic sclk;
        logic sdat;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // edge detector history
    typedef struct packed {
        logic en_prev;
        logic sclk_prev;
    } edge_st_t;
endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] sync_d [STAGES];
    logic [W-1:0] sync_q [STAGES];

    always_comb begin
        sync_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) sync_q[i] <= '0;
            else     sync_q[i] <= sync_d[i];
        end
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/dcr_ctl.sv
module dcr_ctl
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_s,
    output logic shift_en,
    output logic load_ser,
    output logic load_par
);
    edge_st_t st_d, st_q;
    logic sclk_rise, en_fall, serial;

    always_comb begin
        st_d.en_prev   = ctl_s.en;
        st_d.sclk_prev = ctl_s.sclk;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign serial    = (ctl_s.mode == MODE_SERIAL);
    assign sclk_rise = ctl_s.sclk & ~st_q.sclk_prev;
    assign en_fall   = st_q.en_prev & ~ctl_s.en;
    assign shift_en  = serial & ctl_s.en & sclk_rise;
    assign load_ser  = serial & en_fall;
    assign load_par  = (ctl_s.mode == MODE_PARALLEL) & ctl_s.en;

    // R5/R7: shifting only ever happens with enable high in serial mode
    assert_shift_gated_R7: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> (ctl_s.en && serial));
    // R2: the two load paths never fire together
    assert_load_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(load_ser && load_par));
endmodule

// File: rtl/dcr_shadow.sv
module dcr_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdat,
    output logic [W-1:0] shadow,
    output logic         msb
);
    typedef struct packed {
        logic [W-1:0] sr;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.sr = {st_q.sr[W-2:0], sdat};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shadow = st_q.sr;
    assign msb    = st_q.sr[W-1];

    assert_shift_in_R5: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (shadow[0] == $past(sdat)) &&
                     (shadow[W-1:1] == $past(shadow[W-2:0])));
    assert_no_shift_R7: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(shadow));
endmodule

// File: rtl/dcr_active.sv
module dcr_active #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_par,
    input  logic         load_ser,
    input  logic [W-1:0] pbus,
    input  logic [W-1:0] shadow,
    output logic [W-1:0] code
);
    typedef struct packed {
        logic [W-1:0] code;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_par)      st_d.code = pbus;
        else if (load_ser) st_d.code = shadow;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code = st_q.code;

    assert_commit_R6: assert property (@(posedge clk) disable iff (rst)
        load_ser |=> (code == $past(shadow)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_par && !load_ser) |=> $stable(code));
endmodule

// File: rtl/delay_code_reg.sv
module delay_code_reg
    import dcr_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_par,
    input  logic              en_in,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic [CODE_W-1:0] pbus_in,
    output logic [CODE_W-1:0] code_out,
    output logic              sq_out,
    output logic              sq_oe
);
    localparam int IN_W = CTL_W + CODE_W;

    logic [IN_W-1:0]   raw_in, sync_out;
    ctl_t              ctl_s;
    logic [CODE_W-1:0] pbus_s, shadow;
    logic              shift_en, load_ser, load_par;

    assign raw_in = {mode_par, en_in, sclk_in, sdata_in, pbus_in};

    dcr_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw_in), .dout(sync_out)
    );

    assign ctl_s  = ctl_t'(sync_out[IN_W-1 -: CTL_W]);
    assign pbus_s = sync_out[CODE_W-1:0];

    dcr_ctl u_ctl (
        .clk(clk), .rst(rst), .ctl_s(ctl_s),
        .shift_en(shift_en), .load_ser(load_ser), .load_par(load_par)
    );

    dcr_shadow #(.W(CODE_W)) u_shadow (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdat(ctl_s.sdat),
        .shadow(shadow), .msb(sq_out)
    );

    dcr_active #(.W(CODE_W)) u_active (
        .clk(clk), .rst(rst), .load_par(load_par), .load_ser(load_ser),
        .pbus(pbus_s), .shadow(shadow), .code(code_out)
    );

    assign sq_oe = (ctl_s.mode == MODE_SERIAL);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (code_out == '0) && (sq_out == 1'b0));
    assert_par_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.mode == MODE_PARALLEL && ctl_s.en) |=> (code_out == $past(pbus_s)));
    assert_ser_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.mode == MODE_SERIAL && ctl_s.en) |=> $stable(code_out));
    always_comb begin
        if (!rst) assert_oe_mode_R2: assert (sq_oe != ctl_s.mode);
    end
endmodule

// File: tb/sim_delay_code_reg.sv
module sim_delay_code_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_par = 1'b0, en = 1'b0, sclk = 1'b0, d_drv = 1'b0, loop = 1'b0;
    logic [7:0] pbus = 8'h00;
    logic [7:0] code0, code1;
    logic       q0, q1, oe0, oe1, d0;
    int         checks = 0, fails = 0;

    always #5 clk = ~clk;

    assign d0 = loop ? q1 : d_drv;

    delay_code_reg u0 (
        .clk(clk), .rst(rst), .mode_par(mode_par), .en_in(en), .sclk_in(sclk),
        .sdata_in(d0), .pbus_in(pbus), .code_out(code0), .sq_out(q0), .sq_oe(oe0)
    );
    delay_code_reg u1 (
        .clk(clk), .rst(rst), .mode_par(mode_par), .en_in(en), .sclk_in(sclk),
        .sdata_in(q0), .pbus_in(pbus), .code_out(code1), .sq_out(q1), .sq_oe(oe1)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        d_drv = b; tick(4);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(4);
    endtask

    // first byte ends in u1 (last stage), second in u0
    task automatic serial_write(input logic [7:0] last_b, input logic [7:0] first_b,
                                input logic [7:0] old0, input logic [7:0] old1);
        mode_par = 1'b0; tick(6);
        en = 1'b1; tick(6);
        for (int i = 7; i >= 0; i--) send_bit(last_b[i]);
        check("R6 code held mid-shift u0", code0, old0);
        for (int i = 7; i >= 0; i--) send_bit(first_b[i]);
        check("R6 code held while enabled u0", code0, old0);
        check("R6 code held while enabled u1", code1, old1);
        check("R8 u0 Q shows bit 7", {7'd0, q0}, {7'd0, first_b[7]});
        check("R8 u1 Q shows bit 7", {7'd0, q1}, {7'd0, last_b[7]});
        en = 1'b0; tick(6);
        check("R6 R9 u0 commit on enable fall", code0, first_b);
        check("R6 R9 u1 commit on enable fall", code1, last_b);
    endtask

    task automatic t_reset;
        rst = 1'b1; tick(4);
        rst = 1'b0; tick(4);
        check("R1 reset code u0", code0, 8'h00);
        check("R1 reset code u1", code1, 8'h00);
        check("R1 reset Q", {7'd0, q0}, 8'h00);
        check("R2 oe in serial mode", {7'd0, oe0}, 8'h01);
    endtask

    task automatic t_parallel;
        mode_par = 1'b1; en = 1'b1; pbus = 8'hA5; tick(6);
        check("R2 oe off in parallel mode", {7'd0, oe0}, 8'h00);
        check("R3 transparent A5", code0, 8'hA5);
        pbus = 8'h3C; tick(6);
        check("R3 transparent 3C", code1, 8'h3C);
        en = 1'b0; tick(6);
        pbus = 8'hFF; tick(6);
        check("R4 latched when enable low u0", code0, 8'h3C);
        check("R4 latched when enable low u1", code1, 8'h3C);
    endtask

    task automatic t_ignore_clk;
        mode_par = 1'b0; en = 1'b0; tick(6);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        check("R7 code unchanged after gated clocks u0", code0, 8'hC3);
        check("R7 code unchanged after gated clocks u1", code1, 8'h5A);
        check("R7 Q unchanged after gated clocks", {7'd0, q0}, 8'h01);
    endtask

    task automatic t_readback;
        logic [15:0] exp_bits;
        exp_bits = {8'h5A, 8'hC3};
        loop = 1'b1; en = 1'b1; tick(6);
        for (int i = 15; i >= 0; i--) begin
            check(i >= 8 ? "R8 R9 readback bit last stage" : "R8 R9 readback bit first stage",
                  {7'd0, q1}, {7'd0, exp_bits[i]});
            sclk = 1'b1; tick(4);
            sclk = 1'b0; tick(4);
        end
        en = 1'b0; tick(6);
        loop = 1'b0;
        check("R8 code kept after readback u0", code0, 8'hC3);
        check("R8 code kept after readback u1", code1, 8'h5A);
        check("R8 shadow restored (Q bit 7)", {7'd0, q0}, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(1);
        t_reset();
        t_parallel();
        serial_write(8'h5A, 8'hC3, 8'h3C, 8'h3C);
        t_ignore_clk();
        t_readback();
        serial_write(8'hFF, 8'h00, 8'hC3, 8'h5A);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule